// File: doc/BRIEF.md
# Serial Offset Register Programming Port

This block keeps the almost-empty and almost-full offset values that a FIFO's programmable flag logic compares against. Software or a board controller loads and inspects these values one bit at a time over a three-wire serial link: a serial clock, a data input and a data output. Two active-low enables qualify the link, one for loading and one for readback. A port-select input hands the shared serial pins to boundary-scan logic that lives elsewhere. While that input is high the programming port does nothing.

The two offsets form one chain, least significant bit first. The almost-empty offset comes first and the almost-full offset follows it. Loading shifts the chain toward the almost-empty end, so after a full chain length of writes the first bit sent sits in bit 0 of the almost-empty offset. Readback walks a bit pointer along the same chain. Releasing the read enable, even for a single cycle, sends the pointer back to the first bit. An interrupted read therefore always starts again from the beginning. The parallel offset values are driven straight to the flag comparators.

Top module: `offset_serial_port`

## Requirements
- R1: While rst_n is low, ae_offset takes AE_RST, af_offset takes AF_RST, the read pointer is cleared and sdo is 0.
- R2: On each rising sclk edge where port_sel is 0 and wr_en_n is 0, the chain {af_offset, ae_offset} shifts right by one: sdi enters af_offset bit AF_W-1 and af_offset bit 0 moves into ae_offset bit AE_W-1. A full chain of AE_W+AF_W writes therefore loads the ae_offset LSB first, then the af_offset LSB first.
- R3: On a rising edge where wr_en_n is 1, both offsets keep their values whatever sdi does.
- R4: While port_sel is 1, no bits are loaded, the offsets keep their values, sdo is 0 after the next edge, and the read pointer returns to the first bit.
- R5: On each rising edge where port_sel is 0, rd_en_n is 0 and wr_en_n is 1, sdo is registered with chain bit p and the pointer p advances. Chain bit p is ae_offset[p] for p < AE_W, and af_offset[p-AE_W] otherwise. After an edge where rd_en_n is 1, sdo is 0.
- R6: An edge with rd_en_n high resets the pointer to bit 0, so the next read returns ae_offset[0] again.
- R7: Holding rd_en_n low for AE_W+AF_W edges returns the whole chain. The edge after the last bit returns bit 0 again.
- R8: If wr_en_n and rd_en_n are both 0, the write is performed, sdo is 0 after that edge, and the read pointer holds its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 1 hands the serial pins to boundary scan; 0 enables this port |
| wr_en_n | input | 1 | Active-low serial load enable |
| rd_en_n | input | 1 | Active-low serial readback enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Registered serial data out |
| ae_offset | output | AE_W | Almost-empty offset value |
| af_offset | output | AF_W | Almost-full offset value |

## Verification
The hardest state to reach is an enable conflict in the middle of a readback, with the pointer at a nonzero position. The stimulus first reads three bits, then drops the load enable for one edge while keeping the read enable low. That edge changes the chain contents and does not disturb the pointer. The bench then resumes reading. It predicts from its own model of the shifted chain that the next bit is the new bit 3, and that bit 0 would come back only if the pointer had been wrongly reset.

// File: rtl/offset_serial_port.sv
module offset_serial_port #(
  parameter int AE_W = 16,
  parameter int AF_W = 16,
  parameter logic [AE_W-1:0] AE_RST = 16'h0007,
  parameter logic [AF_W-1:0] AF_RST = 16'h0010
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            port_sel,
  input  logic            wr_en_n,
  input  logic            rd_en_n,
  input  logic            sdi,
  output logic            sdo,
  output logic [AE_W-1:0] ae_offset,
  output logic [AF_W-1:0] af_offset
);
  localparam int NB = AE_W + AF_W;
  localparam int PW = $clog2(NB);
  localparam logic [PW-1:0] PLAST = PW'(NB - 1);

  logic [NB-1:0] chain;
  logic [PW-1:0] ptr;
  logic          wr_go, rd_go;

  assign wr_go = !port_sel && !wr_en_n;
  assign rd_go = !port_sel && !rd_en_n && wr_en_n;

  assign ae_offset = chain[AE_W-1:0];
  assign af_offset = chain[NB-1:AE_W];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)
      chain <= {AF_RST, AE_RST};
    else if (wr_go)
      chain <= {sdi, chain[NB-1:1]};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      sdo <= 1'b0;
    end else if (rd_go) begin
      sdo <= chain[ptr];
      ptr <= (ptr == PLAST) ? '0 : ptr + 1'b1;
    end else begin
      sdo <= 1'b0;
      if (port_sel || rd_en_n)
        ptr <= '0;
    end
  end
endmodule

// File: rtl/offset_serial_port_chk.sv
module offset_serial_port_chk #(
  parameter int AE_W = 16,
  parameter int AF_W = 16
) (
  input logic            sclk,
  input logic            rst_n,
  input logic            port_sel,
  input logic            wr_en_n,
  input logic            rd_en_n,
  input logic            sdi,
  input logic            sdo,
  input logic [AE_W-1:0] ae_offset,
  input logic [AF_W-1:0] af_offset
);
  logic prev_rd_n;
  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) prev_rd_n <= 1'b1;
    else        prev_rd_n <= rd_en_n;

  p_shift_in_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    (!port_sel && !wr_en_n) |=> (af_offset[AF_W-1] == $past(sdi)) &&
                                 (ae_offset[AE_W-1] == $past(af_offset[0])));

  p_hold_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en_n |=> $stable(ae_offset) && $stable(af_offset));

  p_sel_blocks_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    port_sel |=> $stable(ae_offset) && $stable(af_offset) && !sdo);

  p_idle_low_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_en_n |=> !sdo);

  p_first_bit_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    (prev_rd_n && !rd_en_n && wr_en_n && !port_sel) |=> sdo == $past(ae_offset[0]));

  p_conflict_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (!port_sel && !wr_en_n && !rd_en_n) |=> !sdo);
endmodule

bind offset_serial_port offset_serial_port_chk #(.AE_W(AE_W), .AF_W(AF_W)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .port_sel(port_sel), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .sdi(sdi), .sdo(sdo), .ae_offset(ae_offset),
  .af_offset(af_offset)
);

// File: tb/sim_offset_serial_port.sv
`timescale 1ns/1ps
module sim_offset_serial_port;
  localparam int AE_W = 16;
  localparam int AF_W = 16;
  localparam int NB = AE_W + AF_W;
  localparam logic [AE_W-1:0] AE_D = 16'h0007;
  localparam logic [AF_W-1:0] AF_D = 16'h0010;

  logic sclk = 1'b0, rst_n = 1'b0, port_sel = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [AE_W-1:0] ae_offset;
  logic [AF_W-1:0] af_offset;
  logic [NB-1:0] mdl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 sclk = ~sclk;

  offset_serial_port #(.AE_W(AE_W), .AF_W(AF_W), .AE_RST(AE_D), .AF_RST(AF_D)) u0 (
    .sclk(sclk), .rst_n(rst_n), .port_sel(port_sel), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .sdi(sdi), .sdo(sdo), .ae_offset(ae_offset),
    .af_offset(af_offset));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_offsets(string req);
    chk(req, 32'(ae_offset), 32'(mdl[AE_W-1:0]));
    chk(req, 32'(af_offset), 32'(mdl[NB-1:AE_W]));
  endtask

  task automatic shift_in(logic [NB-1:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk); wr_en_n = 1'b0; sdi = v[i];
      mdl = {v[i], mdl[NB-1:1]};
    end
    @(negedge sclk); wr_en_n = 1'b1;
  endtask

  task automatic read_bits(string req, int start, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      if (i > 0) chk(req, 32'(sdo), 32'(mdl[(start + i - 1) % NB]));
      rd_en_n = 1'b0;
    end
    @(negedge sclk);
    chk(req, 32'(sdo), 32'(mdl[(start + n - 1) % NB]));
  endtask

  task automatic t_reset;
    mdl = {AF_D, AE_D};
    rst_n = 1'b0;
    repeat (3) @(negedge sclk);
    chk_offsets("R1");
    chk("R1", 32'(sdo), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_write_full;
    shift_in(32'hA5C3_1E69, NB);
    chk("R2", 32'(ae_offset), 32'h1E69);
    chk("R2", 32'(af_offset), 32'hA5C3);
    shift_in(32'h0000_0005, 3);
    chk_offsets("R2");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 6; i++) begin
      @(negedge sclk); sdi = i[0];
    end
    @(negedge sclk);
    chk_offsets("R3");
  endtask

  task automatic t_read_all;
    shift_in(32'h9E37_79B9, NB);
    read_bits("R5", 0, NB);
    @(negedge sclk); rd_en_n = 1'b1;
    chk("R7", 32'(sdo), 32'(mdl[0]));
    @(negedge sclk);
    chk("R5", 32'(sdo), 32'd0);
  endtask

  task automatic t_wrap;
    read_bits("R7", 0, NB + 3);
    rd_en_n = 1'b1;
    @(negedge sclk);
  endtask

  task automatic t_restart;
    read_bits("R6", 0, 5);
    rd_en_n = 1'b1;
    @(negedge sclk);
    chk("R6", 32'(sdo), 32'd0);
    read_bits("R6", 0, 4);
    rd_en_n = 1'b1;
    @(negedge sclk);
  endtask

  task automatic t_sel;
    logic [NB-1:0] keep;
    keep = mdl;
    @(negedge sclk); port_sel = 1'b1; wr_en_n = 1'b0; sdi = 1'b1;
    repeat (4) @(negedge sclk);
    chk_offsets("R4");
    chk("R4", 32'(mdl), 32'(keep));
    wr_en_n = 1'b1; rd_en_n = 1'b0;
    repeat (3) @(negedge sclk);
    chk("R4", 32'(sdo), 32'd0);
    port_sel = 1'b0;
    @(negedge sclk);
    chk("R4", 32'(sdo), 32'(mdl[0]));
    rd_en_n = 1'b1;
    @(negedge sclk);
  endtask

  task automatic t_conflict;
    logic b;
    shift_in(32'h0F0F_3355, NB);
    read_bits("R8", 0, 3);
    b = ~mdl[0];
    wr_en_n = 1'b0; sdi = b;
    mdl = {b, mdl[NB-1:1]};
    @(negedge sclk);
    chk("R8", 32'(sdo), 32'd0);
    chk_offsets("R8");
    wr_en_n = 1'b1;
    @(negedge sclk);
    chk("R8", 32'(sdo), 32'(mdl[3]));
    rd_en_n = 1'b1;
    @(negedge sclk);
  endtask

  initial begin
    t_reset();
    t_write_full();
    t_hold();
    t_read_all();
    t_wrap();
    t_restart();
    t_sel();
    t_conflict();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule